// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a two-part logical address into a flat linear address. A requester names one of six segment registers and gives a 32-bit byte offset with an access kind. Each segment register holds a 16-bit selector. The selector's low bits pick one entry in a local 16-entry descriptor table. Each 64-bit descriptor gives the segment's base, its byte limit, a code/data type bit and a present bit.

Software-side logic fills the descriptor table through a write port that takes an index and a 64-bit word. The segment registers are loaded through a separate port. For each request, the block either returns the base plus the offset, or raises a fault with a cause code. The answer comes one clock after the request. The block has no caching, no privilege levels and no table walk in memory.

Top module: `seg_xlate`

## Requirements
- R1: A request sampled on a clock edge is answered on the outputs right after that edge. Exactly one of `xl_valid` or `xl_fault` is then high. In a cycle with no request, both are low. `xl_cause` is 0 whenever `xl_fault` is low.
- R2: On success, `xl_linear` equals descriptor base plus offset, modulo 2^32.
- R3: An offset strictly greater than the zero-extended limit faults with cause 1. An offset equal to the limit succeeds.
- R4: The access kind encodings are: 0 read, 1 write, 2 fetch, 3 also read. A write (kind 1) to a code segment (type bit 1) faults with cause 2. A fetch (kind 2) from a data segment (type bit 0) faults with cause 2. Reads of either type pass the type check.
- R5: A descriptor whose present bit is 0 faults with cause 3.
- R6: A selector with any of bits [15:4] set faults with cause 3, whatever the table holds.
- R7: A request naming segment register index 6 or 7 faults with cause 3.
- R8: The descriptor layout is: base in bits [31:0], limit in bits [51:32], type in bit 52, present in bit 53. Bits [63:54] are ignored. A table write takes effect at the clock edge, so a request in the same cycle sees the old entry.
- R9: A segment register load takes effect at the clock edge, so a request in the same cycle sees the old selector.
- R10: Reset clears both outputs, clears every selector to 0, and marks every descriptor not present.
- R11: When several fault conditions hold at once, cause 3 wins over cause 2, and cause 2 wins over cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sreg_ld | input | 1 | Load a segment register |
| sreg_ld_idx | input | 3 | Segment register to load |
| sreg_ld_sel | input | 16 | Selector value to load |
| desc_we | input | 1 | Write a descriptor table entry |
| desc_widx | input | 4 | Table entry to write |
| desc_wdata | input | 64 | Descriptor word |
| req_valid | input | 1 | Translation request |
| req_sreg | input | 3 | Segment register named by the request |
| req_offset | input | 32 | Byte offset within the segment |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 read) |
| xl_valid | output | 1 | Linear address is valid |
| xl_linear | output | 32 | Translated linear address |
| xl_fault | output | 1 | Access refused |
| xl_cause | output | 2 | Fault cause (1 limit, 2 type, 3 absent) |

## Verification
The assertions assume that `rst_n` is deasserted away from the clock edge. They also assume every input is at a defined level on each sampling edge, including `req_sreg` values beyond the sixth register, which they treat as legal stimulus. The bench changes all inputs only on falling edges and releases reset on a falling edge. It drives every segment register index, including the two unused ones, and every access kind against descriptor sets chosen to give each fault cause, its priority overlaps, and an address wrap.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int DESC_W    = 64;
  localparam int ADDR_W    = 32;
  localparam int LIMIT_W   = 20;
  localparam int BASE_LSB  = 0;
  localparam int LIMIT_LSB = 32;
  localparam int TYPE_BIT  = 52;
  localparam int PRES_BIT  = 53;
  localparam int USED_W    = PRES_BIT + 1;

  typedef enum logic [1:0] {
    ACC_READ     = 2'd0,
    ACC_WRITE    = 2'd1,
    ACC_FETCH    = 2'd2,
    ACC_READ_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LIMIT  = 2'd1,
    CAUSE_TYPE   = 2'd2,
    CAUSE_ABSENT = 2'd3
  } xl_cause_e;

  typedef struct packed {
    logic               present;
    logic               is_code;
    logic [LIMIT_W-1:0] limit;
    logic [ADDR_W-1:0]  base;
  } desc_t;

endpackage

// File: rtl/seg_sreg_file.sv
module seg_sreg_file #(
  parameter int NUM_SREG = 6,
  parameter int SEL_W    = 16,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEL_W-1:0] rd_sel,
  output logic             rd_ok
);

  logic [SEL_W-1:0] sel_q [NUM_SREG];

  for (genvar g = 0; g < NUM_SREG; g++) begin : g_sreg
    logic sel_en;
    assign sel_en = ld_en && (ld_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= '0;
      end else if (sel_en) begin
        sel_q[g] <= ld_sel;
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    rd_ok  = 1'b0;
    for (int i = 0; i < NUM_SREG; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_sel = sel_q[i];
        rd_ok  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DESC_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output desc_t             rd_desc
);

  desc_t ent_q [DEPTH];
  desc_t wr_desc;
  logic  unused_hi;

  assign wr_desc.base    = wr_data[BASE_LSB +: ADDR_W];
  assign wr_desc.limit   = wr_data[LIMIT_LSB +: LIMIT_W];
  assign wr_desc.is_code = wr_data[TYPE_BIT];
  assign wr_desc.present = wr_data[PRES_BIT];
  assign unused_hi       = ^wr_data[DESC_W-1:USED_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (ent_en) begin
        ent_q[g] <= wr_desc;
      end
    end
  end

  always_comb begin
    rd_desc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_desc = ent_q[i];
      end
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int TIDX_W = 4
) (
  input  logic              sreg_ok,
  input  logic [SEL_W-1:0]  sel,
  input  desc_t             desc,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] linear,
  output xl_cause_e         cause
);

  logic sel_range_ok;
  logic absent;
  logic type_bad;
  logic over_limit;

  assign sel_range_ok = (sel[SEL_W-1:TIDX_W] == '0);
  assign absent       = !sreg_ok || !sel_range_ok || !desc.present;
  assign type_bad     = ((kind == ACC_WRITE) &&  desc.is_code) ||
                        ((kind == ACC_FETCH) && !desc.is_code);
  assign over_limit   = (offset > {{(ADDR_W-LIMIT_W){1'b0}}, desc.limit});
  assign linear       = desc.base + offset;

  always_comb begin
    if (absent) begin
      cause = CAUSE_ABSENT;
    end else if (type_bad) begin
      cause = CAUSE_TYPE;
    end else if (over_limit) begin
      cause = CAUSE_LIMIT;
    end else begin
      cause = CAUSE_NONE;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter  int NUM_SREG  = 6,
  parameter  int TBL_DEPTH = 16,
  parameter  int SEL_W     = 16,
  localparam int SIDX_W    = $clog2(NUM_SREG),
  localparam int TIDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sreg_ld,
  input  logic [SIDX_W-1:0] sreg_ld_idx,
  input  logic [SEL_W-1:0]  sreg_ld_sel,
  input  logic              desc_we,
  input  logic [TIDX_W-1:0] desc_widx,
  input  logic [DESC_W-1:0] desc_wdata,
  input  logic              req_valid,
  input  logic [SIDX_W-1:0] req_sreg,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_kind,
  output logic              xl_valid,
  output logic [ADDR_W-1:0] xl_linear,
  output logic              xl_fault,
  output logic [1:0]        xl_cause
);

  logic [SEL_W-1:0]  cur_sel;
  logic              cur_sreg_ok;
  desc_t             cur_desc;
  logic [ADDR_W-1:0] chk_linear;
  xl_cause_e         chk_cause;

  seg_sreg_file #(
    .NUM_SREG (NUM_SREG),
    .SEL_W    (SEL_W),
    .IDX_W    (SIDX_W)
  ) u_sregs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (sreg_ld),
    .ld_idx (sreg_ld_idx),
    .ld_sel (sreg_ld_sel),
    .rd_idx (req_sreg),
    .rd_sel (cur_sel),
    .rd_ok  (cur_sreg_ok)
  );

  seg_desc_table #(
    .DEPTH (TBL_DEPTH),
    .IDX_W (TIDX_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (desc_we),
    .wr_idx  (desc_widx),
    .wr_data (desc_wdata),
    .rd_idx  (cur_sel[TIDX_W-1:0]),
    .rd_desc (cur_desc)
  );

  seg_check #(
    .SEL_W  (SEL_W),
    .TIDX_W (TIDX_W)
  ) u_check (
    .sreg_ok (cur_sreg_ok),
    .sel     (cur_sel),
    .desc    (cur_desc),
    .kind    (req_kind),
    .offset  (req_offset),
    .linear  (chk_linear),
    .cause   (chk_cause)
  );

  logic       valid_d;
  logic       fault_d;
  logic [1:0] cause_d;
  logic       lin_en;

  always_comb begin
    valid_d = req_valid && (chk_cause == CAUSE_NONE);
    fault_d = req_valid && (chk_cause != CAUSE_NONE);
    cause_d = fault_d ? chk_cause : CAUSE_NONE;
    lin_en  = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_fault <= 1'b0;
      xl_cause <= CAUSE_NONE;
    end else begin
      xl_valid <= valid_d;
      xl_fault <= fault_d;
      xl_cause <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_linear <= '0;
    end else if (lin_en) begin
      xl_linear <= chk_linear;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NUM_SREG = 6,
  parameter int SIDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [SIDX_W-1:0] req_sreg,
  input logic              xl_valid,
  input logic              xl_fault,
  input logic [1:0]        xl_cause
);

  logic bad_sreg;
  assign bad_sreg = ({1'b0, req_sreg} >= (SIDX_W+1)'(NUM_SREG));

  AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_valid && xl_fault)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!xl_valid && !xl_fault)); // R1

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (xl_valid || xl_fault)); // R1

  AST_CAUSE_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault == (xl_cause != 2'd0)); // R1

  AST_BAD_SREG_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_sreg) |=> (xl_fault && xl_cause == 2'd3)); // R7

endmodule

bind seg_xlate seg_xlate_chk #(
  .NUM_SREG (NUM_SREG),
  .SIDX_W   (SIDX_W)
) u_xlate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_sreg  (req_sreg),
  .xl_valid  (xl_valid),
  .xl_fault  (xl_fault),
  .xl_cause  (xl_cause)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;

  logic        clk;
  logic        rst_n;
  logic        sreg_ld;
  logic [2:0]  sreg_ld_idx;
  logic [15:0] sreg_ld_sel;
  logic        desc_we;
  logic [3:0]  desc_widx;
  logic [63:0] desc_wdata;
  logic        req_valid;
  logic [2:0]  req_sreg;
  logic [31:0] req_offset;
  logic [1:0]  req_kind;
  logic        xl_valid;
  logic [31:0] xl_linear;
  logic        xl_fault;
  logic [1:0]  xl_cause;

  int n_tests;
  int n_fail;

  logic [63:0] desc_m [16];
  logic [15:0] sel_m  [6];

  seg_xlate u_seg_xlate (
    .clk         (clk),
    .rst_n       (rst_n),
    .sreg_ld     (sreg_ld),
    .sreg_ld_idx (sreg_ld_idx),
    .sreg_ld_sel (sreg_ld_sel),
    .desc_we     (desc_we),
    .desc_widx   (desc_widx),
    .desc_wdata  (desc_wdata),
    .req_valid   (req_valid),
    .req_sreg    (req_sreg),
    .req_offset  (req_offset),
    .req_kind    (req_kind),
    .xl_valid    (xl_valid),
    .xl_linear   (xl_linear),
    .xl_fault    (xl_fault),
    .xl_cause    (xl_cause)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  // Expected result from the requirements; tag names the rule exercised.
  function automatic void model(input int s, input logic [1:0] k,
                                input logic [31:0] off,
                                output logic v, output logic f,
                                output logic [1:0] c, output logic [31:0] l,
                                output string tag);
    logic [15:0] sel;
    logic [63:0] d;
    logic absent, tbad, lbad;
    int nconds;
    sel = (s < 6) ? sel_m[s] : 16'h0;
    d   = desc_m[sel[3:0]];
    absent = (s >= 6) || (sel[15:4] != 0) || !d[53];
    tbad   = (k == 2'd1 && d[52]) || (k == 2'd2 && !d[52]);
    lbad   = off > {12'h0, d[51:32]};
    l = d[31:0] + off;
    nconds = int'(absent) + int'(tbad) + int'(lbad);
    if (absent)    c = 2'd3;
    else if (tbad) c = 2'd2;
    else if (lbad) c = 2'd1;
    else           c = 2'd0;
    v = (c == 2'd0);
    f = !v;
    if (nconds > 1)            tag = "R11";
    else if (s >= 6)           tag = "R7";
    else if (sel[15:4] != 0)   tag = "R6";
    else if (absent)           tag = "R5";
    else if (tbad)             tag = "R4";
    else if (lbad)             tag = "R3";
    else                       tag = "R2";
  endfunction

  task automatic check(input string tag, input logic ev, input logic ef,
                       input logic [1:0] ec, input logic [31:0] el);
    n_tests++;
    if (xl_valid !== ev || xl_fault !== ef || xl_cause !== ec ||
        (ev && xl_linear !== el)) begin
      n_fail++;
      $display("FAIL %s: actual v=%b f=%b c=%0d lin=%h expected v=%b f=%b c=%0d lin=%h",
               tag, xl_valid, xl_fault, xl_cause, xl_linear, ev, ef, ec, el);
    end
  endtask

  task automatic clear_strobes();
    sreg_ld   = 1'b0;
    desc_we   = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic load_desc(input int i, input logic [63:0] d);
    @(negedge clk);
    clear_strobes();
    desc_we    = 1'b1;
    desc_widx  = 4'(i);
    desc_wdata = d;
    desc_m[i]  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic load_sreg(input int s, input logic [15:0] sel);
    @(negedge clk);
    clear_strobes();
    sreg_ld     = 1'b1;
    sreg_ld_idx = 3'(s);
    sreg_ld_sel = sel;
    sel_m[s]    = sel;
    @(posedge clk);
    #1;
  endtask

  task automatic do_req(input int s, input logic [1:0] k, input logic [31:0] off);
    logic ev, ef;
    logic [1:0] ec;
    logic [31:0] el;
    string tag;
    @(negedge clk);
    clear_strobes();
    req_valid  = 1'b1;
    req_sreg   = 3'(s);
    req_kind   = k;
    req_offset = off;
    model(s, k, off, ev, ef, ec, el, tag);
    @(posedge clk);
    #1;
    check(tag, ev, ef, ec, el);
  endtask

  task automatic idle_check();
    @(negedge clk);
    clear_strobes();
    @(posedge clk);
    #1;
    check("R1 idle", 1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  function automatic logic [63:0] make_desc(input int i);
    logic [31:0] base;
    logic [19:0] lim;
    logic        is_code, pres;
    base    = (i == 15) ? 32'hFFFF_F000 : (32'h0010_0000 * i + 32'h0000_0ABC);
    lim     = 20'(i * 32'h1_1111);
    is_code = i[0];
    pres    = (i % 5) != 4;
    return {10'h2A5, pres, is_code, lim, base};
  endfunction

  function automatic logic [15:0] pass_sel(input int p, input int k);
    case (p)
      0: return 16'(k);
      1: case (k)
           0: return 16'd15;
           1: return 16'd14;
           2: return 16'd9;
           3: return 16'd1;
           4: return 16'h0013;
           default: return 16'h8007;
         endcase
      default: return 16'(10 + k);
    endcase
  endfunction

  initial begin
    logic [31:0] lim;
    logic [31:0] offs [5];
    n_tests = 0;
    n_fail  = 0;
    rst_n = 1'b0;
    clear_strobes();
    sreg_ld_idx = '0; sreg_ld_sel = '0;
    desc_widx = '0; desc_wdata = '0;
    req_sreg = '0; req_offset = '0; req_kind = '0;
    for (int i = 0; i < 16; i++) desc_m[i] = '0;
    for (int i = 0; i < 6; i++) sel_m[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 outputs in reset", 1'b0, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R10 outputs after reset", 1'b0, 1'b0, 2'd0, 32'h0);

    // R10: selector 0 and entry 0 not present after reset
    do_req(0, 2'd0, 32'h0);
    idle_check();

    for (int i = 0; i < 16; i++) load_desc(i, make_desc(i));

    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 6; k++) load_sreg(k, pass_sel(p, k));
      for (int s = 0; s < 8; s++) begin
        lim = (s < 6) ? {12'h0, desc_m[sel_m[s][3:0]][51:32]} : 32'h0;
        offs[0] = 32'h0;
        offs[1] = lim;
        offs[2] = lim + 32'h1;
        offs[3] = lim >> 1;
        offs[4] = 32'hFFFF_FFFF;
        for (int kd = 0; kd < 4; kd++) begin
          for (int o = 0; o < 5; o++) do_req(s, 2'(kd), offs[o]);
        end
      end
      idle_check();
    end

    // R8: table write and request on the same edge -> old entry used
    for (int k = 0; k < 6; k++) load_sreg(k, 16'(k));
    @(negedge clk);
    clear_strobes();
    desc_we    = 1'b1;
    desc_widx  = 4'd2;
    desc_wdata = {10'h000, 1'b1, 1'b0, 20'h00100, 32'h4000_0000};
    req_valid  = 1'b1;
    req_sreg   = 3'd2;
    req_kind   = 2'd0;
    req_offset = 32'h10;
    @(posedge clk);
    #1;
    check("R8 same-cycle write sees old entry", 1'b1, 1'b0, 2'd0,
          desc_m[2][31:0] + 32'h10);
    desc_m[2] = {10'h000, 1'b1, 1'b0, 20'h00100, 32'h4000_0000};
    do_req(2, 2'd0, 32'h10);
    do_req(2, 2'd1, 32'h101);

    // R9: selector load and request on the same edge -> old selector used
    @(negedge clk);
    clear_strobes();
    sreg_ld     = 1'b1;
    sreg_ld_idx = 3'd3;
    sreg_ld_sel = 16'd4;
    req_valid   = 1'b1;
    req_sreg    = 3'd3;
    req_kind    = 2'd0;
    req_offset  = 32'h0;
    @(posedge clk);
    #1;
    check("R9 same-cycle load sees old selector", 1'b1, 1'b0, 2'd0,
          desc_m[3][31:0]);
    sel_m[3] = 16'd4;
    do_req(3, 2'd0, 32'h0);
    idle_check();

    summary();
    $finish;
  end

endmodule